// File: doc/BRIEF.md
# Auxiliary System-Control Register Block

This block is a small byte-wide register bank that sits on a simple synchronous bus inside a workstation I/O companion chip. It holds a configuration byte, two auxiliary bytes, a diagnostic byte and a modem-control byte. It also decodes a write-only system-control port and a power-management port that does nothing. Software reads each register back one cycle after it asserts the read enable.

The second auxiliary register carries a sticky power-fail flag. This flag follows a synchronous power-fail input, gated by an enable bit in the configuration byte. The flag and the enable together drive a level interrupt. Writing the second auxiliary register can clear the flag. It can also request a shutdown through a one-cycle pulse. A write to the system-control port can request a system reset through another one-cycle pulse.

Two resets are used. The ordinary reset clears the bank but leaves the diagnostic byte alone. The diagnostic byte is cleared only by a separate power-on reset.

Top module: `sysaux_regs`

## Requirements
- R1: While and after the ordinary reset (rstN low), configuration, aux1, aux2 and modem control read 0x00, and irqOut, shutdownReq and resetReq are low.
- R2: The diagnostic byte keeps its value through the ordinary reset and is cleared to 0x00 only by the power-on reset (porN low).
- R3: The configuration (select 0x180), aux1 (0x190), diagnostic (0x1A0) and modem-control (0x1B0) registers store the whole written byte. A read with busRdEn returns the value held before that cycle's edge on busRdData in the next cycle. busRdData is 0x00 in a cycle that follows no read.
- R4: The register is selected by busAddr[27:16] only, and bits [15:0] are ignored. The system-control (0x1F0) and power-management (0xA00) ports read 0x00. A write to the power-management port or to any undecoded select changes no register, and reads of undecoded selects return 0x00.
- R5: In a cycle where powerFail differs from its value in the previous cycle, aux2 bit 2 becomes powerFail AND configuration bit 3 (the value held before that edge). This overrides any aux2 write in the same cycle. powerFail is taken as 0 at reset.
- R6: An aux2 write (select 0x191) stores {current bit 2, data[1:0]}. If data bit 1 is set, it stores only data bit 0 instead, which clears bit 2. aux2 reads back as its 3 bits zero-extended to 8 bits.
- R7: irqOut is high exactly when aux2 bit 2 and configuration bit 3 are both set.
- R8: shutdownReq is high for one cycle, in the cycle after an aux2 write whose data bit 0 is set (stored bit 0 = 1). It is low otherwise.
- R9: resetReq is high for one cycle, in the cycle after a system-control write with data bit 0 set. It is low otherwise, and the port stores nothing.
- R10: Once a write has cleared the power-fail flag, the flag stays clear while powerFail holds its level. Only a change of powerFail sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Ordinary reset, active low, asynchronous |
| porN | input | 1 | Power-on reset for the diagnostic byte, active low |
| busAddr | input | 28 | Byte address; bits [27:16] select the register |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, valid the cycle after busRdEn |
| powerFail | input | 1 | Power-fail status, already synchronous to clk |
| irqOut | output | 1 | Level power-fail interrupt |
| shutdownReq | output | 1 | One-cycle shutdown request |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is a cleared power-fail flag while powerFail stays high. Random traffic rarely holds powerFail steady long enough to show that the flag does not come back. It also rarely lines up an aux2 write with a powerFail change in the same cycle. Directed steps therefore set the enable and raise powerFail, clear the flag through an aux2 write, and idle with powerFail still high. They then force a powerFail change in the same cycle as an aux2 write. After that, seeded random traffic across all selects checks every output cycle by cycle against the bench model.

// File: rtl/sysaux_pkg.sv
package sysaux_pkg;
  localparam int ADDR_W = 28;
  localparam int DATA_W = 8;
  localparam int SEL_HI = 27;
  localparam int SEL_LO = 16;
  localparam int SEL_W  = SEL_HI - SEL_LO + 1;
  localparam int AUX2_W = 3;

  localparam logic [SEL_W-1:0] OFS_CFG   = 12'h180;
  localparam logic [SEL_W-1:0] OFS_AUX1  = 12'h190;
  localparam logic [SEL_W-1:0] OFS_AUX2  = 12'h191;
  localparam logic [SEL_W-1:0] OFS_DIAG  = 12'h1A0;
  localparam logic [SEL_W-1:0] OFS_MCTRL = 12'h1B0;
  localparam logic [SEL_W-1:0] OFS_SYS   = 12'h1F0;
  localparam logic [SEL_W-1:0] OFS_PM    = 12'hA00;

  localparam int PF_BIT    = 2;  // aux2 sticky fail flag
  localparam int CLR_BIT   = 1;  // aux2 write: clear fail flag
  localparam int OFF_BIT   = 0;  // aux2 write: shutdown
  localparam int IRQEN_BIT = 3;  // config: fail interrupt enable
  localparam int SYSRST_BIT = 0; // system control: reset

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_AUX1, SEL_AUX2, SEL_DIAG, SEL_MCTRL, SEL_SYS, SEL_PM
  } regSel_e;

  typedef struct packed {
    logic    wrCfg;
    logic    wrAux1;
    logic    wrAux2;
    logic    wrDiag;
    logic    wrMctrl;
    logic    wrSys;
    logic    rdEn;
    regSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/sysaux_decode.sv
module sysaux_decode
  import sysaux_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobes_t          strb
);
  regSel_e sel;

  always_comb begin
    case (busAddr[SEL_HI:SEL_LO])
      OFS_CFG:   sel = SEL_CFG;
      OFS_AUX1:  sel = SEL_AUX1;
      OFS_AUX2:  sel = SEL_AUX2;
      OFS_DIAG:  sel = SEL_DIAG;
      OFS_MCTRL: sel = SEL_MCTRL;
      OFS_SYS:   sel = SEL_SYS;
      OFS_PM:    sel = SEL_PM;
      default:   sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.wrCfg   = busWrEn && (sel == SEL_CFG);
    strb.wrAux1  = busWrEn && (sel == SEL_AUX1);
    strb.wrAux2  = busWrEn && (sel == SEL_AUX2);
    strb.wrDiag  = busWrEn && (sel == SEL_DIAG);
    strb.wrMctrl = busWrEn && (sel == SEL_MCTRL);
    strb.wrSys   = busWrEn && (sel == SEL_SYS);
    strb.rdEn    = busRdEn;
    strb.rdSel   = sel;
  end
endmodule

// File: rtl/sysaux_datapath.sv
module sysaux_datapath
  import sysaux_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              powerFail,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              shutdownReq,
  output logic              resetReq
);
  logic [DATA_W-1:0] cfgQ, aux1Q, diagQ, mctrlQ;
  logic [AUX2_W-1:0] aux2Q, aux2Nxt;
  logic              pfPrevQ;
  logic              pfEvent;
  logic [DATA_W-1:0] rdMux;

  assign pfEvent = (powerFail != pfPrevQ);

  // aux2 next value: bus write first, power-fail event last (it wins bit 2)
  always_comb begin
    aux2Nxt = aux2Q;
    if (strb.wrAux2) begin
      if (wrData[CLR_BIT])
        aux2Nxt = {{(AUX2_W-1){1'b0}}, wrData[OFF_BIT]};
      else
        aux2Nxt = {aux2Q[PF_BIT], wrData[CLR_BIT:OFF_BIT]};
    end
    if (pfEvent)
      aux2Nxt[PF_BIT] = powerFail & cfgQ[IRQEN_BIT];
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CFG:   rdMux = cfgQ;
      SEL_AUX1:  rdMux = aux1Q;
      SEL_AUX2:  rdMux = {{(DATA_W-AUX2_W){1'b0}}, aux2Q};
      SEL_DIAG:  rdMux = diagQ;
      SEL_MCTRL: rdMux = mctrlQ;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ        <= '0;
      aux1Q       <= '0;
      aux2Q       <= '0;
      mctrlQ      <= '0;
      pfPrevQ     <= 1'b0;
      rdData      <= '0;
      shutdownReq <= 1'b0;
      resetReq    <= 1'b0;
    end else begin
      if (strb.wrCfg)   cfgQ   <= wrData;
      if (strb.wrAux1)  aux1Q  <= wrData;
      if (strb.wrMctrl) mctrlQ <= wrData;
      aux2Q       <= aux2Nxt;
      pfPrevQ     <= powerFail;
      rdData      <= strb.rdEn ? rdMux : '0;
      shutdownReq <= strb.wrAux2 & aux2Nxt[OFF_BIT];
      resetReq    <= strb.wrSys & wrData[SYSRST_BIT];
    end
  end

  // diagnostic byte lives in the power-on reset domain only
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)            diagQ <= '0;
    else if (strb.wrDiag) diagQ <= wrData;
  end

  assign irqOut = aux2Q[PF_BIT] & cfgQ[IRQEN_BIT];
endmodule

// File: rtl/sysaux_regs.sv
module sysaux_regs
  import sysaux_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              powerFail,
  output logic              irqOut,
  output logic              shutdownReq,
  output logic              resetReq
);
  strobes_t strb;

  sysaux_decode u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  sysaux_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .porN        (porN),
    .strb        (strb),
    .wrData      (busWrData),
    .powerFail   (powerFail),
    .rdData      (busRdData),
    .irqOut      (irqOut),
    .shutdownReq (shutdownReq),
    .resetReq    (resetReq)
  );
endmodule

// File: rtl/sysaux_regs_chk.sv
module sysaux_regs_chk
  import sysaux_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              powerFail,
  input logic              irqOut,
  input logic              shutdownReq,
  input logic              resetReq
);
  // R9: a reset pulse only follows a system-control write with bit 0 set
  assert_reset_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(busWrEn && busAddr[SEL_HI:SEL_LO] == OFS_SYS && busWrData[SYSRST_BIT]));

  // R8: a shutdown pulse only follows an aux2 write with bit 0 set
  assert_shutdown_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(busWrEn && busAddr[SEL_HI:SEL_LO] == OFS_AUX2 && busWrData[OFF_BIT]));

  // R3: read data is nonzero only in the cycle after a read strobe
  assert_rd_after_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData != '0) |-> $past(busRdEn));

  // R7: the interrupt can only be high while the last sampled fail level was high
  assert_irq_needs_fail_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(powerFail));
endmodule

bind sysaux_regs sysaux_regs_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrData   (busWrData),
  .busWrEn     (busWrEn),
  .busRdEn     (busRdEn),
  .busRdData   (busRdData),
  .powerFail   (powerFail),
  .irqOut      (irqOut),
  .shutdownReq (shutdownReq),
  .resetReq    (resetReq)
);

// File: tb/sysaux_regs_test.sv
module sysaux_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        porN = 1'b0;
  logic [27:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busRdData;
  logic        powerFail = 1'b0;
  logic        irqOut, shutdownReq, resetReq;

  int total = 0;
  int bad = 0;

  // bench model
  logic [7:0] mCfg, mAux1, mDiag, mMctrl;
  logic [2:0] mAux2;
  logic       mPfPrev;

  localparam logic [27:0] A_CFG = 28'h180_0000, A_AUX1 = 28'h190_0000,
    A_AUX2 = 28'h191_0000, A_DIAG = 28'h1A0_0000, A_MCTRL = 28'h1B0_0000,
    A_SYS = 28'h1F0_0000, A_PM = 28'hA00_0000, A_BAD = 28'h170_0000;

  always #2.5 clk = ~clk;

  sysaux_regs uut (
    .clk(clk), .rstN(rstN), .porN(porN), .busAddr(busAddr),
    .busWrData(busWrData), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busRdData(busRdData), .powerFail(powerFail), .irqOut(irqOut),
    .shutdownReq(shutdownReq), .resetReq(resetReq)
  );

  function automatic logic [7:0] modelRead(input logic [27:0] a);
    case (a[27:16])
      12'h180: return mCfg;
      12'h190: return mAux1;
      12'h191: return {5'b0, mAux2};
      12'h1A0: return mDiag;
      12'h1B0: return mMctrl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [27:0] a, input logic [7:0] d, input logic we,
                      input logic re, input logic pf, input string tag);
    logic [7:0] eRd, oldCfg;
    logic       eSh, eRs;
    logic [2:0] nAux2;
    busAddr = a; busWrData = d; busWrEn = we; busRdEn = re; powerFail = pf;
    eRd = re ? modelRead(a) : 8'h00;
    eSh = we && a[27:16] == 12'h191 && d[0];
    eRs = we && a[27:16] == 12'h1F0 && d[0];
    oldCfg = mCfg;
    nAux2 = mAux2;
    if (we) begin
      case (a[27:16])
        12'h180: mCfg = d;
        12'h190: mAux1 = d;
        12'h1A0: mDiag = d;
        12'h1B0: mMctrl = d;
        12'h191: nAux2 = d[1] ? {2'b00, d[0]} : {mAux2[2], d[1:0]};
        default: ;
      endcase
    end
    if (pf != mPfPrev) nAux2[2] = pf & oldCfg[3];
    mAux2 = nAux2;
    mPfPrev = pf;
    @(posedge clk); #2;
    check(busRdData, eRd, tag);
    check({7'b0, irqOut}, {7'b0, mAux2[2] & mCfg[3]}, "R7 irqOut");
    check({7'b0, shutdownReq}, {7'b0, eSh}, "R8 shutdownReq");
    check({7'b0, resetReq}, {7'b0, eRs}, "R9 resetReq");
    busWrEn = 1'b0; busRdEn = 1'b0;
  endtask

  task automatic wr(input logic [27:0] a, input logic [7:0] d, input string tag);
    step(a, d, 1'b1, 1'b0, powerFail, tag);
  endtask

  task automatic rdChk(input logic [27:0] a, input string tag);
    step(a, 8'h00, 1'b0, 1'b1, powerFail, tag);
    step(a, 8'h00, 1'b0, 1'b0, powerFail, tag);
  endtask

  task automatic doReset(input logic por);
    powerFail = 1'b0;
    busWrEn = 1'b0; busRdEn = 1'b0;
    rstN = 1'b0;
    if (por) porN = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs low while held in reset
    check(busRdData, 8'h00, "R1 rdData in reset");
    check({5'b0, irqOut, shutdownReq, resetReq}, 8'h00, "R1 outputs in reset");
    rstN = 1'b1; porN = 1'b1;
    mCfg = 0; mAux1 = 0; mAux2 = 0; mMctrl = 0; mPfPrev = 0;
    if (por) mDiag = 0;
    @(posedge clk); #2;
  endtask

  initial begin
    #(5ns * 100000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    mDiag = 0;
    doReset(1'b1);
    // R1 / R2 reset values
    rdChk(A_CFG, "R1 cfg");  rdChk(A_AUX1, "R1 aux1");
    rdChk(A_AUX2, "R1 aux2"); rdChk(A_MCTRL, "R1 mctrl");
    rdChk(A_DIAG, "R2 diag after por");

    // R3 full-byte storage
    wr(A_CFG, 8'hA5, "R3"); wr(A_AUX1, 8'h5A, "R3");
    wr(A_DIAG, 8'h3C, "R3"); wr(A_MCTRL, 8'hFF, "R3");
    rdChk(A_CFG, "R3 cfg"); rdChk(A_AUX1, "R3 aux1");
    rdChk(A_DIAG, "R3 diag"); rdChk(A_MCTRL, "R3 mctrl");

    // R4 decode on bits 27:16 only, ignored ports
    rdChk(A_CFG | 28'h0_1234, "R4 low bits ignored");
    wr(A_MCTRL | 28'h0_FFFF, 8'h81, "R4");
    rdChk(A_MCTRL, "R4 write with low bits");
    wr(A_BAD, 8'hFF, "R4"); wr(A_PM, 8'hFF, "R4");
    rdChk(A_BAD, "R4 undecoded"); rdChk(A_PM, "R4 pm");
    rdChk(A_SYS, "R4 sys");
    rdChk(A_CFG, "R4 cfg untouched"); rdChk(A_AUX1, "R4 aux1 untouched");
    rdChk(A_AUX2, "R4 aux2 untouched"); rdChk(A_DIAG, "R4 diag untouched");

    // R2 ordinary reset keeps diag
    doReset(1'b0);
    rdChk(A_DIAG, "R2 diag kept"); rdChk(A_CFG, "R1 cfg after rst");

    // R5 / R6 / R7 / R10 power-fail flag
    wr(A_CFG, 8'h08, "R5");
    step(A_CFG, 8'h00, 1'b0, 1'b0, 1'b1, "R5 pf rise");
    rdChk(A_AUX2, "R5 flag set");
    wr(A_AUX2, 8'h00, "R6");
    rdChk(A_AUX2, "R6 flag kept");
    wr(A_AUX2, 8'h02, "R6");
    rdChk(A_AUX2, "R6 flag cleared");
    repeat (5) step(A_CFG, 8'h00, 1'b0, 1'b0, 1'b1, "R10 hold");
    rdChk(A_AUX2, "R10 stays clear");
    step(A_CFG, 8'h00, 1'b0, 1'b0, 1'b0, "R5 pf fall");
    step(A_AUX2, 8'h02, 1'b1, 1'b0, 1'b1, "R5 event beats write");
    rdChk(A_AUX2, "R5 event beats write");
    wr(A_CFG, 8'h00, "R7 irq off");
    wr(A_CFG, 8'h08, "R7 irq on");
    step(A_CFG, 8'h00, 1'b0, 1'b0, 1'b0, "R5 pf fall");
    wr(A_CFG, 8'h00, "R5");
    step(A_CFG, 8'h00, 1'b0, 1'b0, 1'b1, "R5 gated rise");
    rdChk(A_AUX2, "R5 gated off");

    // R8 / R9 pulses
    wr(A_AUX2, 8'h01, "R8");
    wr(A_AUX2, 8'h03, "R8");
    rdChk(A_AUX2, "R6 aux2 reads 1");
    wr(A_AUX2, 8'hFC, "R6");
    rdChk(A_AUX2, "R6 only low bits");
    wr(A_SYS, 8'h01, "R9"); wr(A_SYS, 8'hFE, "R9");
    rdChk(A_SYS, "R9 sys reads 0");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [27:0] a;
      logic pf;
      case ($urandom % 9)
        0: a = A_CFG;  1: a = A_AUX1; 2: a = A_AUX2; 3: a = A_DIAG;
        4: a = A_MCTRL; 5: a = A_SYS; 6: a = A_PM;
        7: a = A_AUX2 | 28'($urandom % 65536);
        default: a = {$urandom % 4096, 16'h0};
      endcase
      pf = (($urandom % 8) == 0) ? ~powerFail : powerFail;
      step(a, 8'($urandom), 1'($urandom), 1'($urandom), pf, "R3 random read");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule